// File: doc/BRIEF.md
# Read Configuration Register Command Unit

This block owns the 16-bit read configuration word of a flash-style memory. It watches the asynchronous bus controls (active-low chip select, write strobe and address-valid strobe) together with the address and data buses. Two consecutive bus writes load the word: a setup command, then a confirm command. The value loaded is taken from the address bus, not from the data bus. Every control and bus line is passed through a synchronizer into the block clock domain. A write cycle begins when chip select and write strobe are both seen low. The cycle is captured exactly once, on whichever of the three strobes is first seen rising.

The stored word is decoded into the controls that the read path uses: asynchronous or synchronous-burst selection, latency count, burst order and burst length. The unit also reports whether its command machine is in array-read mode. A sticky error flag marks a setup that was followed by a wrong confirm.

Top module: `rcr_cmd_unit`

## Requirements
- R1: After reset the register holds 16'hBBCF, `array_read` is 1 and `seq_err` is 0.
- R2: A write whose data low byte is 8'h60, followed by a write whose data low byte is 8'h03, loads the register with the address bus value of the second write.
- R3: The upper data byte is ignored when the command is decoded, and the data bus never supplies the register value.
- R4: When a setup is followed by any low byte other than 8'h03, the register keeps its value, `seq_err` goes to 1 and the unit returns to array-read mode. `seq_err` stays at 1 until the next accepted setup, which clears it.
- R5: A confirm write (8'h03) that arrives with no setup pending leaves the register unchanged.
- R6: A write cycle produces exactly one capture, even when more than one strobe rises during it.
- R7: The address is taken at the first rising strobe. A change on the address bus after that strobe, within the same write cycle, is not loaded.
- R8: `read_async` equals register bit 15. A 1 selects asynchronous random reads and a 0 selects synchronous burst reads.
- R9: `lat_count` equals register bits 13:11 and `burst_order` equals register bit 7.
- R10: The burst length is decoded from register bits 2:0. The code 3'b001 gives 4 words, 3'b010 gives 8 words and 3'b011 gives 16 words. The code 3'b111 gives `burst_cont`=1 with `burst_words`=0. Every other code gives `burst_len_ok`=0 with `burst_words`=0.
- R11: `array_read` is 0 while a setup is pending. It returns to 1 on the cycle the register loads.
- R12: In array-read mode, a write whose low byte is neither 8'h60 nor 8'h03 does nothing visible at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | 16 | Address bus; carries the new register value on confirm |
| data | input | 16 | Data bus; its low byte carries the command code |
| cfg_q | output | 16 | Current register value |
| read_async | output | 1 | 1 = asynchronous random read, 0 = synchronous burst |
| lat_count | output | 3 | Latency count field |
| burst_order | output | 1 | Burst order field |
| burst_words | output | 5 | Decoded burst length in words (0 if continuous or reserved) |
| burst_cont | output | 1 | Continuous burst selected |
| burst_len_ok | output | 1 | Burst length code is a defined code |
| array_read | output | 1 | Command machine is in array-read mode |
| seq_err | output | 1 | Sticky flag for an aborted set sequence |

## Verification
The checker assumes that the address and data buses are stable from before the first strobe edge until several clocks after it, so that the synchronised bus and the synchronised strobes stay aligned. It also assumes that each control level lasts for at least a few block clocks. The bench drives every bus change on the falling clock edge and holds each control level for three or more cycles. Buses change only when the bench intends it, which is when it checks R7 after the first strobe has already risen. The properties then cover the single capture per write cycle, that an abort leaves the register unchanged, and that a load happens only from the setup-pending state.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int unsigned CFG_W = 16;
  localparam logic [7:0] CMD_SETUP   = 8'h60;
  localparam logic [7:0] CMD_CONFIRM = 8'h03;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hBBCF;

  // field positions inside the configuration word
  localparam int unsigned MODE_BIT  = 15;
  localparam int unsigned LAT_HI    = 13;
  localparam int unsigned LAT_LO    = 11;
  localparam int unsigned ORDER_BIT = 7;
  localparam int unsigned BLEN_HI   = 2;
  localparam int unsigned BLEN_LO   = 0;

  typedef enum logic {ST_ARRAY = 1'b0, ST_SETUP = 1'b1} cmd_st_t;
endpackage

// File: rtl/rcr_strobe_sync.sv
module rcr_strobe_sync #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          evt,
  output logic [AW-1:0] evt_addr,
  output logic [DW-1:0] evt_data
);
  localparam int unsigned NCTL = 3; // {adv, we, ce}

  logic [NCTL-1:0] ctl_p [STAGES];
  logic [AW-1:0]   adr_p [STAGES];
  logic [DW-1:0]   dat_p [STAGES];
  logic [NCTL-1:0] ctl_s, ctl_q;
  logic            wr_act, wr_now, wr_was, rise, fire;

  // stage 0 samples the pins; later stages are generated
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_p[0] <= '1;
      adr_p[0] <= '0;
      dat_p[0] <= '0;
    end else begin
      ctl_p[0] <= {adv_n, we_n, ce_n};
      adr_p[0] <= addr;
      dat_p[0] <= data;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl_p[g] <= '1;
        adr_p[g] <= '0;
        dat_p[g] <= '0;
      end else begin
        ctl_p[g] <= ctl_p[g-1];
        adr_p[g] <= adr_p[g-1];
        dat_p[g] <= dat_p[g-1];
      end
    end
  end

  assign ctl_s  = ctl_p[STAGES-1];
  assign wr_now = ~ctl_s[0] & ~ctl_s[1];
  assign wr_was = ~ctl_q[0] & ~ctl_q[1];
  assign rise   = |(ctl_s & ~ctl_q);
  assign fire   = wr_act & rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '1;
      wr_act   <= 1'b0;
      evt      <= 1'b0;
      evt_addr <= '0;
      evt_data <= '0;
    end else begin
      ctl_q <= ctl_s;
      evt   <= fire;
      if (fire) begin
        wr_act   <= 1'b0;
        evt_addr <= adr_p[STAGES-1];
        evt_data <= dat_p[STAGES-1];
      end else if (wr_now && !wr_was) begin
        wr_act <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rcr_cmd_fsm.sv
module rcr_cmd_fsm
  import rcr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [AW-1:0]    evt_addr,
  input  logic [DW-1:0]    evt_data,
  output logic [CFG_W-1:0] cfg,
  output logic             array_rd,
  output logic             err
);
  cmd_st_t    st;
  logic [7:0] code;

  assign code     = evt_data[7:0];
  assign array_rd = (st == ST_ARRAY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_ARRAY;
      cfg <= CFG_RESET;
      err <= 1'b0;
    end else if (evt) begin
      unique case (st)
        ST_ARRAY: if (code == CMD_SETUP) begin
          st  <= ST_SETUP;
          err <= 1'b0;
        end
        ST_SETUP: begin
          st <= ST_ARRAY;
          if (code == CMD_CONFIRM) cfg <= evt_addr[CFG_W-1:0];
          else                     err <= 1'b1;
        end
        default: st <= ST_ARRAY;
      endcase
    end
  end
endmodule

// File: rtl/rcr_field_decode.sv
module rcr_field_decode
  import rcr_pkg::*;
#(
  parameter int unsigned WORDS_W = 5
) (
  input  logic [CFG_W-1:0]   cfg,
  output logic               async_rd,
  output logic [2:0]         lat,
  output logic               order,
  output logic [WORDS_W-1:0] words,
  output logic               cont,
  output logic               len_ok
);
  logic [2:0] code;

  assign async_rd = cfg[MODE_BIT];
  assign lat      = cfg[LAT_HI:LAT_LO];
  assign order    = cfg[ORDER_BIT];
  assign code     = cfg[BLEN_HI:BLEN_LO];

  always_comb begin
    words  = '0;
    cont   = 1'b0;
    len_ok = 1'b1;
    case (code)
      3'b001:  words = WORDS_W'(4);
      3'b010:  words = WORDS_W'(8);
      3'b011:  words = WORDS_W'(16);
      3'b111:  cont  = 1'b1;
      default: len_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/rcr_cmd_unit.sv
module rcr_cmd_unit
  import rcr_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WORDS_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               adv_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      data,
  output logic [CFG_W-1:0]   cfg_q,
  output logic               read_async,
  output logic [2:0]         lat_count,
  output logic               burst_order,
  output logic [WORDS_W-1:0] burst_words,
  output logic               burst_cont,
  output logic               burst_len_ok,
  output logic               array_read,
  output logic               seq_err
);
  logic          cap_evt;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;

  rcr_strobe_sync #(.AW(AW), .DW(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
    .addr(addr), .data(data),
    .evt(cap_evt), .evt_addr(cap_addr), .evt_data(cap_data)
  );

  rcr_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt(cap_evt), .evt_addr(cap_addr),
    .evt_data(cap_data), .cfg(cfg_q), .array_rd(array_read), .err(seq_err)
  );

  rcr_field_decode #(.WORDS_W(WORDS_W)) u_dec (
    .cfg(cfg_q), .async_rd(read_async), .lat(lat_count), .order(burst_order),
    .words(burst_words), .cont(burst_cont), .len_ok(burst_len_ok)
  );
endmodule

// File: rtl/rcr_cmd_unit_chk.sv
module rcr_cmd_unit_chk #(
  parameter int unsigned WORDS_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cap_evt,
  input logic [15:0]        cfg_q,
  input logic               array_read,
  input logic               seq_err,
  input logic [WORDS_W-1:0] burst_words,
  input logic               burst_cont,
  input logic               burst_len_ok
);
  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_q == 16'hBBCF && array_read && !seq_err));

  a_r6_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);

  a_r4_abort_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err) |-> $stable(cfg_q));

  a_r11_load_returns_array: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> array_read);

  a_r5_load_needs_setup: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(!array_read));

  a_r10_cont_no_len: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont |-> (burst_words == '0 && burst_len_ok));
endmodule

bind rcr_cmd_unit rcr_cmd_unit_chk #(.WORDS_W(WORDS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cfg_q(cfg_q),
  .array_read(array_read), .seq_err(seq_err), .burst_words(burst_words),
  .burst_cont(burst_cont), .burst_len_ok(burst_len_ok)
);

// File: tb/rcr_cmd_unit_test.sv
module rcr_cmd_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  typedef struct packed {
    logic [15:0] a;
    logic        as;
    logic [2:0]  lat;
    logic        ord;
    logic [4:0]  words;
    logic        cont;
    logic        ok;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{16'h0001, 1'b0, 3'd0, 1'b0, 5'd4,  1'b0, 1'b1},
    '{16'h8812, 1'b1, 3'd1, 1'b0, 5'd8,  1'b0, 1'b1},
    '{16'h3883, 1'b0, 3'd7, 1'b1, 5'd16, 1'b0, 1'b1},
    '{16'h1007, 1'b0, 3'd2, 1'b0, 5'd0,  1'b1, 1'b1},
    '{16'h0004, 1'b0, 3'd0, 1'b0, 5'd0,  1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, adv_n = 1'b1;
  logic [15:0] addr = '0, data = '0;
  logic [15:0] cfg_q;
  logic read_async, burst_order, burst_cont, burst_len_ok, array_read, seq_err;
  logic [2:0] lat_count;
  logic [4:0] burst_words;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rcr_cmd_unit uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .adv_n(adv_n),
    .addr(addr), .data(data), .cfg_q(cfg_q), .read_async(read_async),
    .lat_count(lat_count), .burst_order(burst_order), .burst_words(burst_words),
    .burst_cont(burst_cont), .burst_len_ok(burst_len_ok),
    .array_read(array_read), .seq_err(seq_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one bus write; with_adv: address strobe rises first, then address is disturbed
  task automatic bus_write(input logic [15:0] a, input logic [15:0] d, input bit with_adv);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; we_n = 1'b0; adv_n = with_adv ? 1'b0 : 1'b1;
    idle(4);
    if (with_adv) begin
      adv_n = 1'b1;
      idle(4);
      addr = ~a;
      idle(3);
    end
    we_n = 1'b1;
    idle(8);
    ce_n = 1'b1;
    idle(3);
  endtask

  task automatic check_fields(input string tag, input vec_t v);
    check({tag, " R2 cfg"}, 32'(cfg_q), 32'(v.a));
    check({tag, " R8 async"}, 32'(read_async), 32'(v.as));
    check({tag, " R9 lat"}, 32'(lat_count), 32'(v.lat));
    check({tag, " R9 order"}, 32'(burst_order), 32'(v.ord));
    check({tag, " R10 words"}, 32'(burst_words), 32'(v.words));
    check({tag, " R10 cont"}, 32'(burst_cont), 32'(v.cont));
    check({tag, " R10 ok"}, 32'(burst_len_ok), 32'(v.ok));
    check({tag, " R11 array"}, 32'(array_read), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state, decoded through R8/R9/R10
    check("R1 cfg", 32'(cfg_q), 32'h0000BBCF);
    check("R1 array", 32'(array_read), 32'd1);
    check("R1 err", 32'(seq_err), 32'd0);
    check("R1 R8 async", 32'(read_async), 32'd1);
    check("R1 R9 lat", 32'(lat_count), 32'd7);
    check("R1 R10 cont", 32'(burst_cont), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      bus_write(16'h0000, 16'h0060, 1'b0);
      check("R11 pending", 32'(array_read), 32'd0);
      bus_write(VECS[i].a, 16'h0003, 1'b0);
      check_fields($sformatf("vec%0d", i), VECS[i]);
    end

    // R3 upper data byte ignored, value from address bus
    bus_write(16'h0000, 16'hA560, 1'b0);
    bus_write(16'h2345, 16'h4403, 1'b0);
    check("R3 cfg from addr", 32'(cfg_q), 32'h2345);

    // R4 abort
    bus_write(16'h0000, 16'h0060, 1'b0);
    bus_write(16'h1111, 16'h00FF, 1'b0);
    check("R4 cfg kept", 32'(cfg_q), 32'h2345);
    check("R4 err set", 32'(seq_err), 32'd1);
    check("R4 array", 32'(array_read), 32'd1);
    bus_write(16'h0000, 16'h0060, 1'b0);
    check("R4 err cleared", 32'(seq_err), 32'd0);
    bus_write(16'h0101, 16'h0003, 1'b0);
    check("R4 reload", 32'(cfg_q), 32'h0101);

    // R5 confirm without setup
    bus_write(16'h5555, 16'h0003, 1'b0);
    check("R5 cfg kept", 32'(cfg_q), 32'h0101);
    check("R5 array", 32'(array_read), 32'd1);

    // R12 unrelated command in array mode
    bus_write(16'h7777, 16'h0070, 1'b0);
    check("R12 cfg kept", 32'(cfg_q), 32'h0101);
    check("R12 array", 32'(array_read), 32'd1);
    check("R12 err", 32'(seq_err), 32'd0);

    // R6/R7 two strobes rise per cycle; first one captures
    bus_write(16'h0000, 16'h0060, 1'b1);
    check("R6 single capture pending", 32'(array_read), 32'd0);
    check("R6 no err", 32'(seq_err), 32'd0);
    bus_write(16'h0C0B, 16'h0003, 1'b1);
    check("R7 first-edge addr", 32'(cfg_q), 32'h0C0B);
    check("R6 array", 32'(array_read), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule